// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a serial-access storage array used as a programmable digital delay line for video samples. Words enter through a write port on one clock and leave through a read port on a second clock. The two clocks are unrelated and may run at different rates. Each port has its own address counter, and each counter returns to zero only when that port's clear strobe is applied. The delay between a word going in and the same word coming out is therefore set by how far apart the two clear strobes are. Neither port has random addressing.

Each port has two controls. One freezes the port, so its address does not move and nothing happens. The other lets the address keep moving but suppresses the data. On the write side it leaves the addressed word untouched, which supports picture-in-picture overlays. On the read side it switches the output pad enable off, so samples can be skipped.

All write-side inputs are captured on one write edge and take effect on the next. This lets the registered output of one instance feed the write input of another directly.

Top module: `field_delay_mem`

## Requirements
- R1: While `rstN` is low and right after it rises, `rdDrive` is 0 and `rdData` is all zeros.
- R2: A read-clock edge with `rdClear` high sets the read address to 0 and leaves `rdData` and `rdDrive` unchanged. The next advancing read edge returns location 0.
- R3: A read-clock edge with `rdRun` high and `rdClear` low loads `rdData` from the current read address, sets `rdDrive` from `rdShow`, and moves the read address up by one.
- R4: A read-clock edge with `rdRun` low and `rdClear` low keeps the read address, `rdData` and `rdDrive` unchanged.
- R5: When `rdShow` is low on an advancing read edge, `rdDrive` is 0 and `rdData` reads as all zeros after that edge, while the read address still moves up by one.
- R6: `wrClear`, `wrRun`, `wrPass` and `wrData` sampled on a write edge act on the array and the write address at the following write edge.
- R7: A `wrClear` sampled high sets the write address to 0 one write edge later, and no word is written on that edge.
- R8: When `wrRun` is sampled low, the following write edge neither writes a word nor moves the write address.
- R9: When `wrRun` is sampled high and `wrPass` low, the following write edge leaves the addressed word unchanged but still moves the write address up by one.
- R10: Both address counters wrap from DEPTH-1 to 0 when no clear is applied.
- R11: With both clocks identical and both ports running continuously, `rdData` after write edge t equals the `wrData` driven before edge t-D. D is the number of edges from the write clear to the read clear, and D must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wClk | input | 1 | Write-port clock |
| rClk | input | 1 | Read-port clock |
| rstN | input | 1 | Asynchronous active-low reset for both ports |
| wrClear | input | 1 | Clears the write address (takes effect one edge later) |
| wrRun | input | 1 | Lets the write port advance; low freezes it |
| wrPass | input | 1 | High stores the word; low keeps the old word but still advances |
| wrData | input | WIDTH | Word to be stored |
| rdClear | input | 1 | Clears the read address |
| rdRun | input | 1 | Lets the read port advance; low freezes it |
| rdShow | input | 1 | High drives the fetched word; low turns the pad enable off but still advances |
| rdData | output | WIDTH | Registered read word, all zeros when not driven |
| rdDrive | output | 1 | Pad output enable for `rdData` |

## Verification
A wrong write address shows up at the read port only after the read counter reaches the misplaced word. Depending on where the two clears sit, that can be up to one full DEPTH of read edges later. The bench therefore reads back every affected location after each write scenario. A wrong read address or a wrong enable capture appears on the very next advancing read edge, as a wrong word or a wrong `rdDrive`. A missing write lag only affects words read within one edge of being written, so it is exercised through the minimum two-edge delay.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  // Write-side strobes, produced from the staged controls
  typedef struct packed {
    logic clear;
    logic step;
    logic commit;
  } wrStrobe_t;

  // Read-side strobes, produced from the live controls
  typedef struct packed {
    logic clear;
    logic step;
    logic show;
  } rdStrobe_t;
endpackage

// File: rtl/fdm_ctrl.sv
module fdm_ctrl
  import fdm_pkg::*;
(
  input  logic      wClk,
  input  logic      rstN,
  input  logic      wrClear,
  input  logic      wrRun,
  input  logic      wrPass,
  input  logic      rdClear,
  input  logic      rdRun,
  input  logic      rdShow,
  output wrStrobe_t wrStb,
  output rdStrobe_t rdStb
);
  logic clearQ, runQ, passQ;

  // one-edge lag on every write control
  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      clearQ <= 1'b0;
      runQ   <= 1'b0;
      passQ  <= 1'b0;
    end else begin
      clearQ <= wrClear;
      runQ   <= wrRun;
      passQ  <= wrPass;
    end
  end

  always_comb begin
    wrStb.clear  = clearQ;
    wrStb.step   = runQ & ~clearQ;
    wrStb.commit = runQ & ~clearQ & passQ;
  end

  always_comb begin
    rdStb.clear = rdClear;
    rdStb.step  = rdRun & ~rdClear;
    rdStb.show  = rdShow;
  end
endmodule

// File: rtl/fdm_datapath.sv
module fdm_datapath
  import fdm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             wClk,
  input  logic             rClk,
  input  logic             rstN,
  input  wrStrobe_t        wrStb,
  input  rdStrobe_t        rdStb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             rdDrive,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] dataQ, outQ;
  logic             driveQ;
  logic [AW-1:0]    wrNext, rdNext;

  // wrap logic: free-running for power-of-two depth, compare otherwise
  generate
    if (DEPTH == (1 << AW)) begin : g_wrap_pow2
      assign wrNext = wrAddr + 1'b1;
      assign rdNext = rdAddr + 1'b1;
    end else begin : g_wrap_cmp
      assign wrNext = (wrAddr == LAST) ? '0 : wrAddr + 1'b1;
      assign rdNext = (rdAddr == LAST) ? '0 : rdAddr + 1'b1;
    end
  endgenerate

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
      dataQ  <= '0;
    end else begin
      dataQ <= wrData;
      if (wrStb.clear)     wrAddr <= '0;
      else if (wrStb.step) wrAddr <= wrNext;
    end
  end

  always_ff @(posedge wClk) begin
    if (wrStb.commit) store[wrAddr] <= dataQ;
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      outQ   <= '0;
      driveQ <= 1'b0;
    end else if (rdStb.clear) begin
      rdAddr <= '0;
    end else if (rdStb.step) begin
      outQ   <= store[rdAddr];
      driveQ <= rdStb.show;
      rdAddr <= rdNext;
    end
  end

  assign rdData  = driveQ ? outQ : '0;
  assign rdDrive = driveQ;
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
  import fdm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             wClk,
  input  logic             rClk,
  input  logic             rstN,
  input  logic             wrClear,
  input  logic             wrRun,
  input  logic             wrPass,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdClear,
  input  logic             rdRun,
  input  logic             rdShow,
  output logic [WIDTH-1:0] rdData,
  output logic             rdDrive
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  wrStrobe_t     wrStb;
  rdStrobe_t     rdStb;
  logic [AW-1:0] wrAddr, rdAddr;

  fdm_ctrl u_ctrl (
    .wClk(wClk), .rstN(rstN),
    .wrClear(wrClear), .wrRun(wrRun), .wrPass(wrPass),
    .rdClear(rdClear), .rdRun(rdRun), .rdShow(rdShow),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  fdm_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .wClk(wClk), .rClk(rClk), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int WIDTH = 8,
  parameter int AW = 5
) (
  input logic             wClk,
  input logic             rClk,
  input logic             rstN,
  input logic             wrClear,
  input logic             wrRun,
  input logic             rdClear,
  input logic             rdRun,
  input logic             rdShow,
  input logic [WIDTH-1:0] rdData,
  input logic             rdDrive,
  input logic [AW-1:0]    wrAddr,
  input logic [AW-1:0]    rdAddr
);
  // R2: read clear zeroes the address and holds the output
  p_clear_holds_r2: assert property (@(posedge rClk) disable iff (!rstN)
    rdClear |=> (rdAddr == '0) && $stable(rdData) && $stable(rdDrive));

  // R4: frozen read port keeps address and output
  p_read_frozen_r4: assert property (@(posedge rClk) disable iff (!rstN)
    (!rdRun && !rdClear) |=> $stable(rdAddr) && $stable(rdData) && $stable(rdDrive));

  // R5: pad enable follows the show control of the advancing edge
  p_show_follows_r5: assert property (@(posedge rClk) disable iff (!rstN)
    (rdRun && !rdClear) |=> (rdDrive == $past(rdShow)));

  // R7: staged write clear zeroes the write address one edge later
  p_wr_clear_lag_r7: assert property (@(posedge wClk) disable iff (!rstN)
    $past(wrClear) |=> (wrAddr == '0));

  // R8: staged freeze keeps the write address
  p_wr_frozen_r8: assert property (@(posedge wClk) disable iff (!rstN)
    $past(!wrRun && !wrClear) |=> $stable(wrAddr));
endmodule

bind field_delay_mem fdm_checker #(.WIDTH(WIDTH), .AW(AW)) u_fdm_chk (
  .wClk(wClk), .rClk(rClk), .rstN(rstN),
  .wrClear(wrClear), .wrRun(wrRun),
  .rdClear(rdClear), .rdRun(rdRun), .rdShow(rdShow),
  .rdData(rdData), .rdDrive(rdDrive),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/tb_field_delay_mem.sv
module tb_field_delay_mem;
  localparam int WIDTH = 8;
  localparam int DEPTH = 32;

  logic wClk = 1'b0, rClk = 1'b0, rstN = 1'b0;
  logic wrClear = 0, wrRun = 0, wrPass = 0, rdClear = 0, rdRun = 0, rdShow = 0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic rdDrive;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 wClk = ~wClk;
  always #2 rClk = ~rClk;

  field_delay_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (.*);

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge on both clocks; returns just after the falling edge
  task automatic tick(logic wc, logic wr, logic wp, logic [WIDTH-1:0] wd,
                      logic rc, logic rr, logic rs);
    wrClear = wc; wrRun = wr; wrPass = wp; wrData = wd;
    rdClear = rc; rdRun = rr; rdShow = rs;
    @(posedge wClk);
    @(negedge wClk);
  endtask

  task automatic idle();
    tick(0, 0, 0, '0, 0, 0, 0);
  endtask

  task automatic fill(logic [WIDTH-1:0] base);
    tick(1, 0, 0, '0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) tick(0, 1, 1, base + WIDTH'(i), 0, 0, 0);
    idle();
  endtask

  task automatic test_reset();
    check("R1 drive", {7'b0, rdDrive}, 8'h00);
    check("R1 data", rdData, 8'h00);
  endtask

  task automatic test_fill_read();
    fill(8'h40);
    tick(0, 0, 0, '0, 1, 0, 0);
    check("R2 data held on clear", rdData, 8'h00);
    for (int a = 0; a < DEPTH; a++) begin
      tick(0, 0, 0, '0, 0, 1, 1);
      check("R3 R7 readback", rdData, 8'h40 + WIDTH'(a));
      check("R3 drive", {7'b0, rdDrive}, 8'h01);
    end
    tick(0, 0, 0, '0, 0, 1, 1);
    check("R10 read wrap", rdData, 8'h40);
    tick(0, 0, 0, '0, 1, 1, 1);
    check("R2 clear holds output", rdData, 8'h40);
    tick(0, 0, 0, '0, 0, 1, 1);
    check("R2 first word after clear", rdData, 8'h40);
  endtask

  task automatic test_write_wrap();
    tick(1, 0, 0, '0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 3; i++) tick(0, 1, 1, 8'h80 + WIDTH'(i), 0, 0, 0);
    idle();
    tick(0, 0, 0, '0, 1, 0, 0);
    for (int a = 0; a < 4; a++) begin
      tick(0, 0, 0, '0, 0, 1, 1);
      check("R10 write wrap", rdData, (a < 3) ? 8'h80 + WIDTH'(DEPTH + a) : 8'h83);
    end
  endtask

  task automatic test_mask();
    fill(8'h10);
    tick(1, 0, 0, '0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) tick(0, 1, (i % 2) == 0, 8'hA0 + WIDTH'(i), 0, 0, 0);
    idle();
    tick(0, 0, 0, '0, 1, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      tick(0, 0, 0, '0, 0, 1, 1);
      check("R9 masked write", rdData, ((a % 2) == 0) ? 8'hA0 + WIDTH'(a) : 8'h10 + WIDTH'(a));
    end
  endtask

  task automatic test_write_freeze();
    fill(8'h20);
    tick(1, 0, 0, '0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick(0, 1, 1, 8'h60 + WIDTH'(i), 0, 0, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 8'hEE, 0, 0, 0);
    for (int i = 4; i < 8; i++) tick(0, 1, 1, 8'h60 + WIDTH'(i), 0, 0, 0);
    idle();
    tick(0, 0, 0, '0, 1, 0, 0);
    for (int a = 0; a < 9; a++) begin
      tick(0, 0, 0, '0, 0, 1, 1);
      check("R8 R6 frozen write", rdData, (a < 8) ? 8'h60 + WIDTH'(a) : 8'h28);
    end
  endtask

  task automatic test_skip();
    tick(0, 0, 0, '0, 1, 0, 0);
    for (int a = 0; a < 6; a++) begin
      bit show = !(a == 2 || a == 3);
      tick(0, 0, 0, '0, 0, 1, show);
      check("R5 drive", {7'b0, rdDrive}, {7'b0, show});
      check("R5 data", rdData, show ? 8'h60 + WIDTH'(a) : 8'h00);
    end
  endtask

  task automatic test_read_freeze();
    tick(0, 0, 0, '0, 1, 0, 0);
    tick(0, 0, 0, '0, 0, 1, 1);
    tick(0, 0, 0, '0, 0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      tick(0, 0, 0, '0, 0, 0, 0);
      check("R4 held data", rdData, 8'h61);
      check("R4 held drive", {7'b0, rdDrive}, 8'h01);
    end
    tick(0, 0, 0, '0, 0, 1, 1);
    check("R4 resumes at next address", rdData, 8'h62);
  endtask

  // R11 R6: streaming delay set by clear spacing
  task automatic test_delay(int d);
    tick(1, 0, 0, '0, 0, 0, 0);
    for (int t = 1; t <= 20; t++) begin
      tick(0, 1, 1, 8'hC0 + WIDTH'(t), t == d, t > d, t > d);
      if (t > d) check("R11 R6 delayed stream", rdData, 8'hC0 + WIDTH'(t - d));
    end
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wClk);
    check("R1 drive in reset", {7'b0, rdDrive}, 8'h00);
    rstN = 1'b1;
    idle();
    test_reset();
    test_fill_read();
    test_write_wrap();
    test_mask();
    test_write_freeze();
    test_skip();
    test_read_freeze();
    test_delay(2);
    test_delay(5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule